// File: doc/BRIEF.md
# Exclusive Lock Sequence Checker

This block is a passive bus monitor. It watches the active-low framing, handshake, target-response and lock signals of a shared parallel bus, plus the 4-bit command field sampled in the address phase. From these it follows every exclusive-access sequence a master opens with the lock signal, from its first transaction until the lock is given up. It reports misuse of the lock as one-cycle error pulses and as sticky error bits. It never drives the bus, never arbitrates, and does not track which target owns the locked resource.

The checker links lock ownership to how each transaction ends. When the target retries the opening transaction of a sequence, the master has to give up the lock. It must also give up the lock after any target abort inside a sequence. The opening transaction has to be a read.

All pins are plain sampled control and status signals, so the block has no valid/ready stream and puts no back-pressure on anything. Every input is sampled on the rising clock edge.

Top module: `lock_seq_checker`

## Requirements
- R1: An address phase is a cycle in which `frame_n` is sampled low while the monitor considers the bus idle. A transaction then runs until the first cycle in which `frame_n` and `irdy_n` are both high, which is its idle cycle. A locked sequence opens only when `lock_n` is high in the address phase and low on the next clock. The sequence closes in any cycle where `lock_n` and `frame_n` are both high.
- R2: When a sequence opens, the command latched in its address phase must be a read. With default parameters the read codes are 4'h6, 4'hC and 4'hE. Any other code raises `err_pulse[0]`.
- R3: In every transaction of an open sequence, `lock_n` must be low on the clock after the address phase. It must stay low through every later cycle up to, but not including, the idle cycle. A breach raises `err_pulse[1]` at most once per transaction.
- R4: A retry is `stop_n` and `devsel_n` low with `trdy_n` high before any data has moved. If a retry occurs in the opening transaction of a sequence and `lock_n` is still low at that transaction's idle cycle, `err_pulse[2]` is raised. A retry in a later transaction of the sequence is not flagged.
- R5: A target abort is `stop_n` low with `devsel_n` high after `devsel_n` was low earlier in the same transaction. If a target abort occurs in any locked transaction and `lock_n` is still low at that transaction's idle cycle, `err_pulse[3]` is raised.
- R6: Each pulse is high for exactly one cycle, starting one clock after the edge that sampled the violation. The matching bit of `err_sticky` rises in that same cycle and stays high until reset.
- R7: While `rst_n` is low, all pulses, all sticky bits and the sequence state are cleared. Once reset ends, a transaction that begins with `lock_n` high is not treated as part of an earlier sequence.
- R8: Transactions outside a locked sequence raise no error, whatever their command, retry or abort outcome. This includes a transaction whose `lock_n` was already low in its address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Sampled frame signal, low while a transaction is in progress |
| irdy_n | input | 1 | Sampled initiator-ready signal |
| trdy_n | input | 1 | Sampled target-ready signal |
| devsel_n | input | 1 | Sampled device-select signal |
| stop_n | input | 1 | Sampled target stop request |
| lock_n | input | 1 | Sampled exclusive-access lock signal |
| bus_cmd | input | CMD_W | Command field, meaningful in the address phase |
| err_pulse | output | 4 | One-cycle violation pulses: [0] opening command not a read, [1] lock not held, [2] lock kept after retry, [3] lock kept after target abort |
| err_sticky | output | 4 | Sticky copies of `err_pulse`, cleared only by reset |

## Verification
The hardest case to reach is a retry seen on the very first clock after the address phase. At that clock the register recording whether the transaction opened the sequence has not yet been updated. A second hard case is a retry in a later transaction of the sequence, which must stay silent.

The stimulus table builds both cases from whole transactions. In one, the target answers with a stop and a device select on the clock right after the address phase, and the lock is released properly. In another, a sequence is kept open across an idle cycle, and a retry then hits its second transaction. Directed tests then check two reset-related cases. One is a reset issued in the middle of a sequence. The other is a transaction whose lock was already low in its address phase.

// File: rtl/lkchk_pkg.sv
package lkchk_pkg;

  localparam int NUM_ERR   = 4;
  localparam int ERR_FIRST = 0;  // opening command was not a read
  localparam int ERR_HOLD  = 1;  // lock not held through a locked transaction
  localparam int ERR_RETRY = 2;  // lock kept after retry of opening transaction
  localparam int ERR_ABORT = 3;  // lock kept after target abort

  typedef logic [NUM_ERR-1:0] err_vec_t;

  // Per-cycle view of the bus transaction, produced by the phase tracker.
  typedef struct packed {
    logic addr;   // address phase this cycle
    logic post;   // first clock after the address phase
    logic busy;   // inside a transaction, past its address phase
    logic endc;   // idle cycle that closes the transaction
    logic retry;  // retry termination seen this cycle
    logic abort;  // target abort seen this cycle
  } phase_t;

endpackage

// File: rtl/lk_bus_phase.sv
module lk_bus_phase
  import lkchk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_n,
  input  logic   irdy_n,
  input  logic   trdy_n,
  input  logic   devsel_n,
  input  logic   stop_n,
  output phase_t ph
);

  logic busy_q;    // transaction in progress after its address phase
  logic post_q;    // the previous cycle was an address phase
  logic moved_q;   // at least one data word has moved
  logic claimed_q; // device select seen earlier in this transaction

  logic addr_now, end_now;

  assign addr_now = !busy_q && !frame_n;
  assign end_now  = busy_q && frame_n && irdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      post_q    <= 1'b0;
      moved_q   <= 1'b0;
      claimed_q <= 1'b0;
    end else begin
      post_q <= addr_now;
      if (addr_now)     busy_q <= 1'b1;
      else if (end_now) busy_q <= 1'b0;

      if (addr_now)                          moved_q <= 1'b0;
      else if (busy_q && !irdy_n && !trdy_n) moved_q <= 1'b1;

      if (addr_now)                 claimed_q <= 1'b0;
      else if (busy_q && !devsel_n) claimed_q <= 1'b1;
    end
  end

  always_comb begin
    ph.addr  = addr_now;
    ph.post  = post_q;
    ph.busy  = busy_q;
    ph.endc  = end_now;
    ph.retry = busy_q && !stop_n && !devsel_n && trdy_n && !moved_q;
    ph.abort = busy_q && !stop_n && devsel_n && claimed_q;
  end

endmodule

// File: rtl/lk_cmd_match.sv
module lk_cmd_match #(
  parameter int                      CMD_W    = 4,
  parameter int                      NUM_RD   = 3,
  parameter logic [NUM_RD*CMD_W-1:0] RD_CODES = {4'hE, 4'hC, 4'h6}
) (
  input  logic [CMD_W-1:0] cmd,
  output logic             is_read
);

  logic [NUM_RD-1:0] hit;

  for (genvar k = 0; k < NUM_RD; k++) begin : g_code
    assign hit[k] = (cmd == RD_CODES[k*CMD_W +: CMD_W]);
  end

  assign is_read = |hit;

endmodule

// File: rtl/lk_seq_rules.sv
module lk_seq_rules
  import lkchk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  phase_t   ph,
  input  logic     frame_n,
  input  logic     lock_n,
  input  logic     is_read,
  output err_vec_t viol
);

  logic seq_q;        // locked sequence open
  logic first_q;      // current transaction opened the sequence
  logic locked_q;     // current transaction belongs to a sequence
  logic held_flag_q;  // hold breach already reported this transaction
  logic pend_rty_q;   // retry seen on the opening transaction
  logic pend_abt_q;   // target abort seen on a locked transaction
  logic addr_lock_q;  // lock_n sampled in the address phase
  logic rd_q;         // address-phase command was a read

  logic starting, first_eff, locked_eff, hold_bad, rty_any, abt_any;

  // On the clock after the address phase the registered flags are
  // still stale, so the live decision is used in that cycle.
  assign starting   = ph.post && !seq_q && addr_lock_q && !lock_n;
  assign first_eff  = ph.post ? starting : first_q;
  assign locked_eff = ph.post ? (starting || seq_q) : locked_q;
  assign hold_bad   = ph.busy && !ph.endc && locked_eff && lock_n && !held_flag_q;
  assign rty_any    = pend_rty_q || (ph.retry && first_eff && locked_eff);
  assign abt_any    = pend_abt_q || (ph.abort && locked_eff);

  always_comb begin
    viol            = '0;
    viol[ERR_FIRST] = starting && !rd_q;
    viol[ERR_HOLD]  = hold_bad;
    viol[ERR_RETRY] = ph.endc && !lock_n && rty_any;
    viol[ERR_ABORT] = ph.endc && !lock_n && abt_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= 1'b0;
      first_q     <= 1'b0;
      locked_q    <= 1'b0;
      held_flag_q <= 1'b0;
      pend_rty_q  <= 1'b0;
      pend_abt_q  <= 1'b0;
      addr_lock_q <= 1'b1;
      rd_q        <= 1'b0;
    end else begin
      if (starting)                seq_q <= 1'b1;
      else if (lock_n && frame_n)  seq_q <= 1'b0;

      if (ph.addr) begin
        addr_lock_q <= lock_n;
        rd_q        <= is_read;
        held_flag_q <= 1'b0;
        pend_rty_q  <= 1'b0;
        pend_abt_q  <= 1'b0;
      end else begin
        if (hold_bad) held_flag_q <= 1'b1;
        pend_rty_q <= ph.endc ? 1'b0 : rty_any;
        pend_abt_q <= ph.endc ? 1'b0 : abt_any;
      end

      if (ph.post) begin
        first_q  <= first_eff;
        locked_q <= locked_eff;
      end
    end
  end

endmodule

// File: rtl/lk_err_report.sv
module lk_err_report
  import lkchk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t viol,
  output err_vec_t pulse,
  output err_vec_t sticky
);

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pulse[i]  <= 1'b0;
        sticky[i] <= 1'b0;
      end else begin
        pulse[i]  <= viol[i];
        sticky[i] <= sticky[i] | viol[i];
      end
    end
  end

endmodule

// File: rtl/lock_seq_checker.sv
module lock_seq_checker
  import lkchk_pkg::*;
#(
  parameter int                      CMD_W    = 4,
  parameter int                      NUM_RD   = 3,
  parameter logic [NUM_RD*CMD_W-1:0] RD_CODES = {4'hE, 4'hC, 4'h6}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic             lock_n,
  input  logic [CMD_W-1:0] bus_cmd,
  output logic [3:0]       err_pulse,
  output logic [3:0]       err_sticky
);

  phase_t   ph;
  logic     is_read;
  err_vec_t viol;

  lk_bus_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .stop_n   (stop_n),
    .ph       (ph)
  );

  lk_cmd_match #(
    .CMD_W    (CMD_W),
    .NUM_RD   (NUM_RD),
    .RD_CODES (RD_CODES)
  ) u_match (
    .cmd     (bus_cmd),
    .is_read (is_read)
  );

  lk_seq_rules u_rules (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph),
    .frame_n (frame_n),
    .lock_n  (lock_n),
    .is_read (is_read),
    .viol    (viol)
  );

  lk_err_report u_report (
    .clk    (clk),
    .rst_n  (rst_n),
    .viol   (viol),
    .pulse  (err_pulse),
    .sticky (err_sticky)
  );

endmodule

// File: rtl/lk_chk_props.sv
module lk_chk_props (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       lock_n,
  input logic [3:0] err_pulse,
  input logic [3:0] err_sticky
);

  // R6: a sticky bit never drops outside reset
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_sticky) & ~err_sticky) == 4'b0));

  // R6: every pulse is mirrored in the sticky bits
  a_r6_pulse_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> ((err_pulse & ~err_sticky) == 4'b0));

  // R6: no bit pulses on two consecutive cycles
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((err_pulse & $past(err_pulse)) == 4'b0));

  // R2: an opening-command error follows a cycle with the lock asserted
  a_r2_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[0] |-> $past(!lock_n));

  // R3: a hold error follows a cycle with the lock released
  a_r3_lock_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[1] |-> $past(lock_n));

  // R4: a retry release error follows an idle cycle with the lock held
  a_r4_idle_locked: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[2] |-> $past(!lock_n && frame_n && irdy_n));

  // R5: an abort release error follows an idle cycle with the lock held
  a_r5_idle_locked: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[3] |-> $past(!lock_n && frame_n && irdy_n));

endmodule

bind lock_seq_checker lk_chk_props u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .lock_n     (lock_n),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky)
);

// File: tb/sim_lock_seq_checker.sv
module sim_lock_seq_checker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic       devsel_n = 1'b1, stop_n = 1'b1, lock_n = 1'b1;
  logic [3:0] bus_cmd = 4'h0;
  logic [3:0] err_pulse, err_sticky;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lock_seq_checker u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .lock_n(lock_n),
    .bus_cmd(bus_cmd), .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  // {frame,irdy,trdy,devsel,stop,lock (all active low), command, expected pulse}
  // expected pulse bits: [0] R2, [1] R3, [2] R4, [3] R5
  localparam int NV = 55;
  localparam logic [13:0] VEC [NV] = '{
    {6'b111111, 4'h0, 4'b0000},
    // R1: good read sequence spanning two transactions
    {6'b011111, 4'h6, 4'b0000}, {6'b101010, 4'h0, 4'b0000},
    {6'b100010, 4'h0, 4'b0000}, {6'b111110, 4'h0, 4'b0000},
    {6'b011111, 4'h7, 4'b0000}, {6'b101010, 4'h0, 4'b0000},
    {6'b100010, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000},
    // R2: sequence opened by a write
    {6'b011111, 4'h7, 4'b0000}, {6'b101010, 4'h0, 4'b0001},
    {6'b100010, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000},
    // R3: lock missing on the clock after address of second transaction
    {6'b011111, 4'h6, 4'b0000}, {6'b101010, 4'h0, 4'b0000},
    {6'b100010, 4'h0, 4'b0000}, {6'b111110, 4'h0, 4'b0000},
    {6'b011111, 4'h6, 4'b0000}, {6'b101011, 4'h0, 4'b0010},
    {6'b100011, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000},
    // R3: lock dropped mid-burst, reported once
    {6'b011111, 4'h6, 4'b0000}, {6'b001010, 4'h0, 4'b0000},
    {6'b000011, 4'h0, 4'b0010}, {6'b100010, 4'h0, 4'b0000},
    {6'b111111, 4'h0, 4'b0000},
    // R4: retry on opening transaction, lock kept
    {6'b011111, 4'h6, 4'b0000}, {6'b001010, 4'h0, 4'b0000},
    {6'b101000, 4'h0, 4'b0000}, {6'b111110, 4'h0, 4'b0100},
    {6'b111111, 4'h0, 4'b0000},
    // R4: fast retry right after address, lock released (code C is a read)
    {6'b011111, 4'hC, 4'b0000}, {6'b101000, 4'h0, 4'b0000},
    {6'b111111, 4'h0, 4'b0000},
    // R4: retry on second transaction is not flagged
    {6'b011111, 4'h6, 4'b0000}, {6'b101010, 4'h0, 4'b0000},
    {6'b100010, 4'h0, 4'b0000}, {6'b111110, 4'h0, 4'b0000},
    {6'b011111, 4'h6, 4'b0000}, {6'b101000, 4'h0, 4'b0000},
    {6'b111110, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000},
    // R5: target abort, lock kept (code E is a read)
    {6'b011111, 4'hE, 4'b0000}, {6'b001010, 4'h0, 4'b0000},
    {6'b101100, 4'h0, 4'b0000}, {6'b111110, 4'h0, 4'b1000},
    {6'b111111, 4'h0, 4'b0000},
    // R5: target abort, lock released
    {6'b011111, 4'h6, 4'b0000}, {6'b001010, 4'h0, 4'b0000},
    {6'b101100, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000},
    // R8: unlocked write raises nothing
    {6'b011111, 4'h7, 4'b0000}, {6'b101011, 4'h0, 4'b0000},
    {6'b100011, 4'h0, 4'b0000}, {6'b111111, 4'h0, 4'b0000}
  };

  function automatic string req_of(int b);
    case (b)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input logic [5:0] sig, input logic [3:0] cmd);
    @(negedge clk);
    {frame_n, irdy_n, trdy_n, devsel_n, stop_n, lock_n} = sig;
    bus_cmd = cmd;
    @(posedge clk);
    #1;
  endtask

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check4("R7", err_pulse, 4'b0000);
    check4("R7", err_sticky, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:8], VEC[i][7:4]);
      n_chk++;
      if (err_pulse !== VEC[i][3:0]) begin
        n_bad++;
        for (int b = 0; b < 4; b++)
          if (err_pulse[b] !== VEC[i][b])
            $display("FAIL %s: vector %0d actual %b expected %b",
                     req_of(b), i, err_pulse[b], VEC[i][b]);
      end
    end

    // R6: every sticky bit holds after the pulses are gone
    drive(6'b111111, 4'h0);
    check4("R6", err_pulse, 4'b0000);
    check4("R6", err_sticky, 4'b1111);

    // R7: reset clears sticky bits
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check4("R7", err_sticky, 4'b0000);
    @(negedge clk); rst_n = 1'b1;

    // R1: lock already low in the address phase does not open a sequence
    drive(6'b111110, 4'h0);
    drive(6'b011110, 4'h7);
    drive(6'b101010, 4'h0);
    check4("R1", err_pulse, 4'b0000);
    drive(6'b101000, 4'h0);   // retry, would matter only if locked
    drive(6'b111110, 4'h0);
    check4("R1", err_pulse, 4'b0000);
    drive(6'b111111, 4'h0);
    check4("R8", err_sticky, 4'b0000);

    // R7: reset inside an open sequence forgets it
    drive(6'b011111, 4'h6);
    drive(6'b101010, 4'h0);
    drive(6'b100010, 4'h0);
    drive(6'b111110, 4'h0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    drive(6'b011111, 4'h6);
    drive(6'b101011, 4'h0);   // lock high: no hold error after reset
    check4("R7", err_pulse, 4'b0000);
    drive(6'b100011, 4'h0);
    drive(6'b111111, 4'h0);
    check4("R7", err_sticky, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule